// File: doc/BRIEF.md
# Word-Addressed Memory-Mapped Register Agent

This block sits on a memory-mapped bus as a target and fronts a small, fixed set of registers. A host issues a read or a write on separate strobe inputs, with a word address, write data and per-byte lane enables. The agent stalls further requests through `waitrequest_o` while it serves one. It answers a read with a one-cycle `rvalid_o` pulse carrying the data. It answers a write with a separate one-cycle `wrvalid_o` pulse. Both carry a two-bit status code.

The register set mixes access kinds. There are two read-write words, a constant identification word, a write-only command word, and a read-only word that echoes the command word. The echo word lets software see what the command word holds. Two build-time switches decide whether an access that misses the map, or one that breaks a word's access kind, returns an error code. With a switch off, the same access completes normally: a read returns zero and a write changes nothing.

Only one request is in flight at a time. Each request takes three cycles from acceptance until the agent can accept the next one.

Top module: `mm_reg_agent`

## Requirements
- R1: The address counts 32-bit words, not bytes. The map is: word 0 read-write control, word 1 read-write scratch, word 2 read-only identification constant `ID_VALUE`, word 3 write-only command, word 4 read-only echo of the command word. Every other address is unmapped.
- R2: A request (`read_i` or `write_i` high) is accepted on a rising edge where `waitrequest_o` is low. `waitrequest_o` is high from the cycle after acceptance through the cycle of the response strobe. It is low again in the cycle after that strobe.
- R3: An accepted read raises `rvalid_o` with `rdata_o` for exactly one cycle, two cycles after the acceptance cycle. An accepted write raises `wrvalid_o` in the same way. The two strobes are never high together.
- R4: `resp_o` is 2'b00 for OK and 2'b10 for error while a strobe is high, and 2'b00 otherwise. `rdata_o` is zero when `rvalid_o` is low.
- R5: On a write, bit i of `byteenable_i` updates byte lane i (bits 8i+7..8i) of the target word. Other lanes keep their value.
- R6: With `ERR_BAD_ADDR` set, an access to an unmapped address returns 2'b10. With it clear, the access returns 2'b00. In both cases a read returns zero and a write changes no register.
- R7: With `ERR_BAD_ACCESS` set, a write to word 2 or word 4, or a read of word 3, returns 2'b10. With it clear, such an access returns 2'b00. Such a write changes no register, and such a read returns zero.
- R8: If `read_i` and `write_i` are high together at acceptance, the read is served and the write is dropped with no register change.
- R9: While `rst_ni` is low (asynchronous, active low), words 0, 1 and 3 are cleared, both strobes are low, and `waitrequest_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| read_i | input | 1 | Read request |
| write_i | input | 1 | Write request |
| address_i | input | AW | Word address |
| writedata_i | input | DW | Write data |
| byteenable_i | input | DW/8 | Write byte lane enables |
| waitrequest_o | output | 1 | Stall; request not accepted while high |
| rvalid_o | output | 1 | Read data valid strobe |
| wrvalid_o | output | 1 | Write complete strobe |
| rdata_o | output | DW | Read data |
| resp_o | output | 2 | Status: 00 OK, 10 error |

## Verification
The assertions assume that the request inputs are known values and that a request counts only at an edge where `waitrequest_o` is low. The agent does not need a host to hold a request through a stall. The bench drives each request in a cycle where the agent is idle and drops it one cycle later. It then keeps the inputs quiet until the agent is idle again. Random operations cover the whole address range, all byte-enable patterns and both strobes at once. Two instances, one with the error switches on and one with them off, see the same stimulus, so both error settings are checked against one register model.

// File: rtl/mm_reg_pkg.sv
package mm_reg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RESP} agent_state_e;
  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_kind_e;

  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_SLVERR = 2'b10;

  localparam int unsigned SLOT_CTRL    = 0;
  localparam int unsigned SLOT_SCRATCH = 1;
  localparam int unsigned SLOT_ID      = 2;
  localparam int unsigned SLOT_CMD     = 3;
  localparam int unsigned SLOT_ECHO    = 4;
  localparam int unsigned SLOT_W       = 3;
endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
  import mm_reg_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic [AW-1:0]     addr_i,
  output acc_kind_e         kind_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    kind_o = ACC_NONE;
    slot_o = '0;
    if (addr_i == AW'(SLOT_CTRL)) begin
      kind_o = ACC_RW; slot_o = SLOT_W'(SLOT_CTRL);
    end else if (addr_i == AW'(SLOT_SCRATCH)) begin
      kind_o = ACC_RW; slot_o = SLOT_W'(SLOT_SCRATCH);
    end else if (addr_i == AW'(SLOT_ID)) begin
      kind_o = ACC_RO; slot_o = SLOT_W'(SLOT_ID);
    end else if (addr_i == AW'(SLOT_CMD)) begin
      kind_o = ACC_WO; slot_o = SLOT_W'(SLOT_CMD);
    end else if (addr_i == AW'(SLOT_ECHO)) begin
      kind_o = ACC_RO; slot_o = SLOT_W'(SLOT_ECHO);
    end
  end
endmodule

// File: rtl/mm_reg_file.sv
module mm_reg_file
  import mm_reg_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter logic [DW-1:0] ID_VALUE = '0,
  localparam int unsigned NB      = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NB-1:0]     be_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] ctrl_q, scratch_q, cmd_q;
  logic [DW-1:0] lane_mask;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{be_i[b]}};
  end

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v);
    return (old_v & ~lane_mask) | (wdata_i & lane_mask);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      scratch_q <= '0;
      cmd_q     <= '0;
    end else if (wr_en_i) begin
      if (slot_i == SLOT_W'(SLOT_CTRL))    ctrl_q    <= merge(ctrl_q);
      if (slot_i == SLOT_W'(SLOT_SCRATCH)) scratch_q <= merge(scratch_q);
      if (slot_i == SLOT_W'(SLOT_CMD))     cmd_q     <= merge(cmd_q);
    end
  end

  always_comb begin
    unique case (slot_i)
      SLOT_W'(SLOT_CTRL):    rdata_o = ctrl_q;
      SLOT_W'(SLOT_SCRATCH): rdata_o = scratch_q;
      SLOT_W'(SLOT_ID):      rdata_o = ID_VALUE;
      SLOT_W'(SLOT_ECHO):    rdata_o = cmd_q;
      default:               rdata_o = '0;
    endcase
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ctrl_q) && $stable(scratch_q) && $stable(cmd_q))); // R7
endmodule

// File: rtl/mm_req_ctrl.sv
module mm_req_ctrl
  import mm_reg_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          read_i,
  input  logic          write_i,
  input  logic [AW-1:0] address_i,
  input  logic [DW-1:0] writedata_i,
  input  logic [NB-1:0] byteenable_i,
  output logic          waitrequest_o,
  output logic          exec_o,
  output logic          cmd_rd_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o,
  output logic [NB-1:0] cmd_be_o,
  input  logic [DW-1:0] exec_rdata_i,
  input  logic          exec_err_i,
  output logic          rvalid_o,
  output logic          wrvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    resp_o
);
  agent_state_e state_q;
  logic accept;

  assign waitrequest_o = (state_q != ST_IDLE);
  assign accept        = (state_q == ST_IDLE) && (read_i || write_i);
  assign exec_o        = (state_q == ST_EXEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cmd_rd_o    <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_wdata_o <= '0;
      cmd_be_o    <= '0;
      rvalid_o    <= 1'b0;
      wrvalid_o   <= 1'b0;
      rdata_o     <= '0;
      resp_o      <= RSP_OKAY;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q     <= ST_EXEC;
          cmd_rd_o    <= read_i;  // read wins when both are set
          cmd_addr_o  <= address_i;
          cmd_wdata_o <= writedata_i;
          cmd_be_o    <= byteenable_i;
        end
        ST_EXEC: begin
          state_q   <= ST_RESP;
          rvalid_o  <= cmd_rd_o;
          wrvalid_o <= !cmd_rd_o;
          rdata_o   <= cmd_rd_o ? exec_rdata_i : '0;
          resp_o    <= exec_err_i ? RSP_SLVERR : RSP_OKAY;
        end
        default: begin
          state_q   <= ST_IDLE;
          rvalid_o  <= 1'b0;
          wrvalid_o <= 1'b0;
          rdata_o   <= '0;
          resp_o    <= RSP_OKAY;
        end
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rvalid_o && wrvalid_o)); // R3
  AST_ACCEPT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((read_i || write_i) && !waitrequest_o) |-> ##2 (rvalid_o || wrvalid_o)); // R3
  AST_STALL_COVERS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o || wrvalid_o) |-> waitrequest_o); // R2
  AST_RELEASE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o || wrvalid_o) |=> !waitrequest_o); // R2
  AST_READ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && write_i && !waitrequest_o) |-> ##2 (rvalid_o && !wrvalid_o)); // R8
  AST_RESP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o == RSP_OKAY) || ((resp_o == RSP_SLVERR) && (rvalid_o || wrvalid_o))); // R4
endmodule

// File: rtl/mm_reg_agent.sv
module mm_reg_agent
  import mm_reg_pkg::*;
#(
  parameter int unsigned   AW             = 4,
  parameter int unsigned   DW             = 32,
  parameter bit            ERR_BAD_ADDR   = 1'b1,
  parameter bit            ERR_BAD_ACCESS = 1'b1,
  parameter logic [DW-1:0] ID_VALUE       = DW'(32'hA5C3_0001),
  localparam int unsigned  NB             = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          read_i,
  input  logic          write_i,
  input  logic [AW-1:0] address_i,
  input  logic [DW-1:0] writedata_i,
  input  logic [NB-1:0] byteenable_i,
  output logic          waitrequest_o,
  output logic          rvalid_o,
  output logic          wrvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    resp_o
);
  logic              exec, cmd_rd, wr_en, exec_err, policy_bad;
  logic [AW-1:0]     cmd_addr;
  logic [DW-1:0]     cmd_wdata, file_rdata, exec_rdata;
  logic [NB-1:0]     cmd_be;
  logic [SLOT_W-1:0] slot;
  acc_kind_e         kind;

  mm_req_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .read_i, .write_i, .address_i, .writedata_i, .byteenable_i,
    .waitrequest_o,
    .exec_o       (exec),
    .cmd_rd_o     (cmd_rd),
    .cmd_addr_o   (cmd_addr),
    .cmd_wdata_o  (cmd_wdata),
    .cmd_be_o     (cmd_be),
    .exec_rdata_i (exec_rdata),
    .exec_err_i   (exec_err),
    .rvalid_o, .wrvalid_o, .rdata_o, .resp_o
  );

  mm_addr_decode #(.AW(AW)) u_dec (
    .addr_i (cmd_addr),
    .kind_o (kind),
    .slot_o (slot)
  );

  assign policy_bad = cmd_rd ? (kind == ACC_WO) : (kind == ACC_RO);
  assign wr_en      = exec && !cmd_rd && ((kind == ACC_RW) || (kind == ACC_WO));
  assign exec_rdata = (cmd_rd && ((kind == ACC_RW) || (kind == ACC_RO))) ? file_rdata : '0;
  assign exec_err   = (kind == ACC_NONE) ? ERR_BAD_ADDR : (policy_bad && ERR_BAD_ACCESS);

  mm_reg_file #(.DW(DW), .ID_VALUE(ID_VALUE)) u_file (
    .clk_i, .rst_ni,
    .wr_en_i (wr_en),
    .slot_i  (slot),
    .wdata_i (cmd_wdata),
    .be_i    (cmd_be),
    .rdata_o (file_rdata)
  );

  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0)); // R4
endmodule

// File: tb/mm_reg_agent_tb.sv
module mm_reg_agent_tb;
  localparam int AW = 4;
  localparam logic [31:0] ID = 32'hA5C3_0001;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] be = '0;
  logic wait_a, rv_a, wv_a, wait_b, rv_b, wv_b;
  logic [31:0] rdata_a, rdata_b;
  logic [1:0] resp_a, resp_b;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] m_ctrl = '0, m_scr = '0, m_cmd = '0;

  always #4 clk = ~clk;

  mm_reg_agent #(.AW(AW), .ERR_BAD_ADDR(1'b1), .ERR_BAD_ACCESS(1'b1), .ID_VALUE(ID)) u_dut (
    .clk_i(clk), .rst_ni, .read_i(rd), .write_i(wr), .address_i(addr), .writedata_i(wdata),
    .byteenable_i(be), .waitrequest_o(wait_a), .rvalid_o(rv_a), .wrvalid_o(wv_a),
    .rdata_o(rdata_a), .resp_o(resp_a));

  mm_reg_agent #(.AW(AW), .ERR_BAD_ADDR(1'b0), .ERR_BAD_ACCESS(1'b0), .ID_VALUE(ID)) u_dut_plain (
    .clk_i(clk), .rst_ni, .read_i(rd), .write_i(wr), .address_i(addr), .writedata_i(wdata),
    .byteenable_i(be), .waitrequest_o(wait_b), .rvalid_o(rv_b), .wrvalid_o(wv_b),
    .rdata_o(rdata_b), .resp_o(resp_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] e);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (e[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  // 0 none, 1 rw, 2 ro, 3 wo
  function automatic int kind_of(input logic [AW-1:0] a);
    case (a)
      0, 1: return 1;
      2, 4: return 2;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (a)
      0: return m_ctrl;
      1: return m_scr;
      2: return ID;
      4: return m_cmd;
      default: return 32'h0;
    endcase
  endfunction

  // called at a negedge with the agents idle; returns at a negedge with them idle
  task automatic access(input bit r, input bit w, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [3:0] e);
    bit is_rd = r;
    int k = kind_of(a);
    bit bad_pol = is_rd ? (k == 3) : (k == 2);
    logic [31:0] exp_rd = is_rd ? model_read(a) : 32'h0;
    logic [1:0] exp_resp = ((k == 0) || bad_pol) ? 2'b10 : 2'b00;
    string tag = (k == 0) ? "R6" : (bad_pol ? "R7" : "R4");
    check("R2 idle", {wait_a, wait_b}, 2'b00);
    rd = r; wr = w; addr = a; wdata = d; be = e;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    check("R2 stall", {wait_a, wait_b}, 2'b11);
    if (!is_rd && (k == 1 || k == 3)) begin
      if (a == 0) m_ctrl = merge(m_ctrl, d, e);
      if (a == 1) m_scr  = merge(m_scr, d, e);
      if (a == 3) m_cmd  = merge(m_cmd, d, e);
    end
    @(negedge clk);
    check(r && w ? "R8 strobes" : "R3 strobes", {rv_a, wv_a, rv_b, wv_b},
          {is_rd, !is_rd, is_rd, !is_rd});
    check("R1 rdata", rdata_a, exp_rd);
    check("R1 rdata plain", rdata_b, exp_rd);
    check(tag, resp_a, exp_resp);
    check("R6 R7 plain resp", resp_b, 2'b00);
    check("R2 stall on strobe", wait_a, 1'b1);
    @(negedge clk);
    check("R3 one-cycle strobe", {rv_a, wv_a, rv_b, wv_b}, 4'b0);
    check("R4 quiet", {resp_a, resp_b}, 4'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {wait_a, rv_a, wv_a, wait_b, rv_b, wv_b}, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset values
    for (int a = 0; a < 5; a++) access(1'b1, 1'b0, AW'(a), 32'h0, 4'h0);
    // R1: word 1 write leaves word 0 alone
    access(1'b0, 1'b1, 4'd1, 32'hDEAD_BEEF, 4'hF);
    access(1'b1, 1'b0, 4'd0, 32'h0, 4'h0);
    access(1'b1, 1'b0, 4'd1, 32'h0, 4'h0);
    // R5 lanes
    access(1'b0, 1'b1, 4'd0, 32'h1122_3344, 4'b0101);
    access(1'b0, 1'b1, 4'd0, 32'hAABB_CCDD, 4'b1000);
    access(1'b1, 1'b0, 4'd0, 32'h0, 4'h0);
    check("R5 lanes", m_ctrl, 32'hAA22_0044);
    // R7 policy
    access(1'b0, 1'b1, 4'd3, 32'hCAFE_F00D, 4'hF);
    access(1'b1, 1'b0, 4'd3, 32'h0, 4'h0);
    access(1'b1, 1'b0, 4'd4, 32'h0, 4'h0);
    access(1'b0, 1'b1, 4'd2, 32'h1234_5678, 4'hF);
    access(1'b0, 1'b1, 4'd4, 32'h1234_5678, 4'hF);
    access(1'b1, 1'b0, 4'd2, 32'h0, 4'h0);
    access(1'b1, 1'b0, 4'd4, 32'h0, 4'h0);
    // R6 unmapped
    access(1'b0, 1'b1, 4'd9, 32'h5555_5555, 4'hF);
    access(1'b1, 1'b0, 4'd15, 32'h0, 4'h0);
    // R8 both at once: read served, write dropped
    access(1'b1, 1'b1, 4'd1, 32'h0BAD_0BAD, 4'hF);
    access(1'b1, 1'b0, 4'd1, 32'h0, 4'h0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      bit r = (sel < 4) || (sel == 9);
      bit w = (sel >= 4);
      access(r, w, AW'($urandom_range(0, 15)), $urandom(), 4'($urandom_range(0, 15)));
    end
    // R9 asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1 check("R9 async reset", {wait_a, rv_a, wv_a}, 3'b0);
    m_ctrl = '0; m_scr = '0; m_cmd = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    access(1'b1, 1'b0, 4'd1, 32'h0, 4'h0);
    access(1'b1, 1'b0, 4'd4, 32'h0, 4'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule